// File: doc/BRIEF.md
# Switch register access bridge

This block lets a host processor reach the paged configuration registers of an Ethernet switch core through a small 32-bit register window. The host first asks for ownership of the switch register path and waits until ownership is granted. It then loads up to 64 bits of write data and issues a single command word. That word names the page, the register offset and the direction. The bridge raises a request toward the switch and holds it until the switch acknowledges. The host polls the busy flag in the command word and, after a read, collects the returned 64 bits from two read words.

The bridge also collects event pulses coming from the switch. These are per-port link changes, a PHY event, a timing-sync event and three sleep-timer events. Each pulse is held in a pending bit until the host clears it by writing a one to that bit. An interrupt line reports whether any event is pending, and a host-controlled enable gates it.

Top module: `sw_reg_bridge`

## Requirements
- R1: After reset the command word (0x2C), the control word (apart from bit 6), the event word (0x44) and the read words (0x38, 0x3C) all read 0, and `swReq` and `irqOut` are low.
- R2: Writing control word 0x40 with bit 3 (request) set makes bit 4 (grant) read 1 one cycle after bit 3 reads 1, provided `arbIdle` is high; while `arbIdle` is low the grant is withheld.
- R3: Once bit 3 reads 0, bit 4 reads 0 one cycle later.
- R4: A write to 0x2C with bit 0 set, made while request and grant are both set and no transfer is in flight, starts a transfer. In the next cycle the word reads back with page in bits 31:24, register in bits 23:16, the direction in bit 1 (1 = write) and bit 0 = 1. `swReq` is high and `swPage`, `swReg` and `swWrite` carry the same fields.
- R5: A command write made while the request bit is clear, or while grant is not yet seen, is dropped: bit 0 stays 0 and `swReq` stays low.
- R6: A command write made while a transfer is in flight is dropped: the command word and the switch-side fields are unchanged.
- R7: The acknowledge may come any number of cycles after the request. On the acknowledge cycle bit 0 of 0x2C clears. For a read transfer, `swRdata` bits 63:32 are captured into 0x38 and bits 31:0 into 0x3C. An acknowledge while idle, or during a write transfer, leaves the read words unchanged.
- R8: The words at 0x30 and 0x34 are readable and form `swWdata` as {0x30, 0x34}. For 48-bit transfers the host uses only bits 15:0 of 0x30, and the bridge forwards the word unchanged.
- R9: Each `evtPulse` bit sets the matching bit of 0x44 (bits 0..12) and the bit stays set. Writing 1 to a bit of 0x44 clears it, writing 0 leaves it, and an all-ones write clears every bit.
- R10: An event pulse that coincides with a clear of the same bit leaves the bit set.
- R11: `irqOut` equals control bit 1 (interrupt enable) ANDed with the OR of all pending bits of 0x44.
- R12: Control bit 6 reads the `initDone` input.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| hostSel | input | 1 | Host access valid |
| hostWe | input | 1 | Host write enable |
| hostAddr | input | 8 | Host byte address |
| hostWdata | input | 32 | Host write data |
| hostRdata | output | 32 | Host read data of the addressed word |
| swReq | output | 1 | Transfer request toward the switch |
| swWrite | output | 1 | Transfer direction, 1 = write |
| swPage | output | 8 | Register page |
| swReg | output | 8 | Register offset in the page |
| swWdata | output | 64 | Data for write transfers |
| swAck | input | 1 | Switch completes the transfer |
| swRdata | input | 64 | Read data, valid with swAck |
| arbIdle | input | 1 | Switch-side arbiter can grant |
| initDone | input | 1 | Switch initialisation complete |
| evtPulse | input | 13 | Event pulses from the switch |
| irqOut | output | 1 | Gated interrupt |

## Verification
The assertions assume that the switch raises `swAck` only for one cycle per request, and that at most one host access arrives per cycle. The stimulus acknowledges each transfer exactly once, after a random delay of zero to four cycles. It also gives a single stray acknowledge while idle, because the bridge is required to drop it. Event pulses and host clears are drawn at random, and some are driven in the same cycle so that the event-over-clear priority is exercised.

// File: rtl/srb_pkg.sv
package srb_pkg;
  localparam int HOST_AW = 8;
  localparam int HOST_DW = 32;
  localparam int FIELD_W = 8;

  // byte offsets of the host words
  localparam logic [HOST_AW-1:0] OFS_CMD = 8'h2C;
  localparam logic [HOST_AW-1:0] OFS_WHI = 8'h30;
  localparam logic [HOST_AW-1:0] OFS_WLO = 8'h34;
  localparam logic [HOST_AW-1:0] OFS_RHI = 8'h38;
  localparam logic [HOST_AW-1:0] OFS_RLO = 8'h3C;
  localparam logic [HOST_AW-1:0] OFS_CTL = 8'h40;
  localparam logic [HOST_AW-1:0] OFS_EVT = 8'h44;

  // bit positions
  localparam int CMD_GO    = 0;
  localparam int CMD_WR    = 1;
  localparam int CMD_REG   = 16;
  localparam int CMD_PAGE  = 24;
  localparam int CTL_IRQEN = 1;
  localparam int CTL_REQ   = 3;
  localparam int CTL_GNT   = 4;
  localparam int CTL_INIT  = 6;

  typedef struct packed {
    logic ldWordHi;
    logic ldWordLo;
    logic clrEvents;
    logic takeRead;
  } dpStrobe_t;

  typedef struct packed {
    logic [FIELD_W-1:0] page;
    logic [FIELD_W-1:0] regOfs;
    logic               isWrite;
    logic               busy;
    logic               irqEn;
    logic               reqBit;
    logic               grant;
  } ctlState_t;
endpackage

// File: rtl/srb_ctrl.sv
module srb_ctrl
  import srb_pkg::*;
(
  input  logic               clk,
  input  logic               rstN,
  input  logic               hostSel,
  input  logic               hostWe,
  input  logic [HOST_AW-1:0] hostAddr,
  input  logic [HOST_DW-1:0] hostWdata,
  input  logic               arbIdle,
  input  logic               swAck,
  output dpStrobe_t          strobe,
  output ctlState_t          st
);
  logic wrHit;
  logic cmdAccept;
  logic ackTake;

  assign wrHit     = hostSel & hostWe;
  assign cmdAccept = wrHit && (hostAddr == OFS_CMD) && hostWdata[CMD_GO]
                     && st.reqBit && st.grant && !st.busy;
  assign ackTake   = st.busy & swAck;

  always_comb begin
    strobe.ldWordHi  = wrHit && (hostAddr == OFS_WHI);
    strobe.ldWordLo  = wrHit && (hostAddr == OFS_WLO);
    strobe.clrEvents = wrHit && (hostAddr == OFS_EVT);
    strobe.takeRead  = ackTake && !st.isWrite;
  end

  // control word bits and ownership grant
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      st.irqEn  <= 1'b0;
      st.reqBit <= 1'b0;
      st.grant  <= 1'b0;
    end else begin
      if (wrHit && (hostAddr == OFS_CTL)) begin
        st.irqEn  <= hostWdata[CTL_IRQEN];
        st.reqBit <= hostWdata[CTL_REQ];
      end
      st.grant <= st.reqBit & (st.grant | arbIdle);
    end
  end

  // command fields and busy flag
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      st.page    <= '0;
      st.regOfs  <= '0;
      st.isWrite <= 1'b0;
      st.busy    <= 1'b0;
    end else if (cmdAccept) begin
      st.page    <= hostWdata[CMD_PAGE +: FIELD_W];
      st.regOfs  <= hostWdata[CMD_REG +: FIELD_W];
      st.isWrite <= hostWdata[CMD_WR];
      st.busy    <= 1'b1;
    end else if (ackTake) begin
      st.busy    <= 1'b0;
    end
  end

  a_r2_grant_rises_on_idle: assert property (@(posedge clk) disable iff (!rstN)
    $rose(st.grant) |-> $past(st.reqBit && arbIdle));
  a_r3_grant_drops: assert property (@(posedge clk) disable iff (!rstN)
    !st.reqBit |=> !st.grant);
  a_r5_busy_needs_grant: assert property (@(posedge clk) disable iff (!rstN)
    $rose(st.busy) |-> $past(st.grant && st.reqBit));
  a_r6_fields_hold: assert property (@(posedge clk) disable iff (!rstN)
    st.busy |=> $stable({st.page, st.regOfs, st.isWrite}));
  a_r7_ack_clears: assert property (@(posedge clk) disable iff (!rstN)
    (st.busy && swAck) |=> !st.busy);
endmodule

// File: rtl/srb_datapath.sv
module srb_datapath
  import srb_pkg::*;
#(
  parameter int NUM_EVT = 13
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  dpStrobe_t            strobe,
  input  ctlState_t            st,
  input  logic [HOST_AW-1:0]   hostAddr,
  input  logic [HOST_DW-1:0]   hostWdata,
  input  logic                 initDone,
  input  logic [NUM_EVT-1:0]   evtPulse,
  input  logic [2*HOST_DW-1:0] swRdata,
  output logic [HOST_DW-1:0]   hostRdata,
  output logic [2*HOST_DW-1:0] swWdata,
  output logic                 irqOut
);
  logic [HOST_DW-1:0] wordHi, wordLo, readHi, readLo;
  logic [NUM_EVT-1:0] pending;
  logic [HOST_DW-1:0] cmdWord, ctlWord;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wordHi <= '0;
      wordLo <= '0;
    end else begin
      if (strobe.ldWordHi) wordHi <= hostWdata;
      if (strobe.ldWordLo) wordLo <= hostWdata;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      readHi <= '0;
      readLo <= '0;
    end else if (strobe.takeRead) begin
      readHi <= swRdata[2*HOST_DW-1:HOST_DW];
      readLo <= swRdata[HOST_DW-1:0];
    end
  end

  // one capture cell per event: a pulse beats a clear
  for (genvar i = 0; i < NUM_EVT; i++) begin : g_evt
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)                                pending[i] <= 1'b0;
      else if (evtPulse[i])                     pending[i] <= 1'b1;
      else if (strobe.clrEvents && hostWdata[i]) pending[i] <= 1'b0;
    end

    a_r10_event_wins: assert property (@(posedge clk) disable iff (!rstN)
      evtPulse[i] |=> pending[i]);
    a_r9_clear_one: assert property (@(posedge clk) disable iff (!rstN)
      (strobe.clrEvents && hostWdata[i] && !evtPulse[i]) |=> !pending[i]);
  end

  always_comb begin
    cmdWord = '0;
    cmdWord[CMD_PAGE +: FIELD_W] = st.page;
    cmdWord[CMD_REG +: FIELD_W]  = st.regOfs;
    cmdWord[CMD_WR]              = st.isWrite;
    cmdWord[CMD_GO]              = st.busy;
    ctlWord = '0;
    ctlWord[CTL_IRQEN] = st.irqEn;
    ctlWord[CTL_REQ]   = st.reqBit;
    ctlWord[CTL_GNT]   = st.grant;
    ctlWord[CTL_INIT]  = initDone;
  end

  always_comb begin
    case (hostAddr)
      OFS_CMD: hostRdata = cmdWord;
      OFS_WHI: hostRdata = wordHi;
      OFS_WLO: hostRdata = wordLo;
      OFS_RHI: hostRdata = readHi;
      OFS_RLO: hostRdata = readLo;
      OFS_CTL: hostRdata = ctlWord;
      OFS_EVT: hostRdata = HOST_DW'(pending);
      default: hostRdata = '0;
    endcase
  end

  assign swWdata = {wordHi, wordLo};
  assign irqOut  = st.irqEn & (|pending);

  a_r7_read_capture: assert property (@(posedge clk) disable iff (!rstN)
    strobe.takeRead |=> ({readHi, readLo} == $past(swRdata)));
  a_r7_no_capture_idle: assert property (@(posedge clk) disable iff (!rstN)
    !strobe.takeRead |=> $stable({readHi, readLo}));
endmodule

// File: rtl/sw_reg_bridge.sv
module sw_reg_bridge
  import srb_pkg::*;
#(
  parameter int NUM_EVT = 13
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 hostSel,
  input  logic                 hostWe,
  input  logic [HOST_AW-1:0]   hostAddr,
  input  logic [HOST_DW-1:0]   hostWdata,
  output logic [HOST_DW-1:0]   hostRdata,
  output logic                 swReq,
  output logic                 swWrite,
  output logic [FIELD_W-1:0]   swPage,
  output logic [FIELD_W-1:0]   swReg,
  output logic [2*HOST_DW-1:0] swWdata,
  input  logic                 swAck,
  input  logic [2*HOST_DW-1:0] swRdata,
  input  logic                 arbIdle,
  input  logic                 initDone,
  input  logic [NUM_EVT-1:0]   evtPulse,
  output logic                 irqOut
);
  dpStrobe_t strobe;
  ctlState_t st;

  srb_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .hostSel(hostSel), .hostWe(hostWe),
    .hostAddr(hostAddr), .hostWdata(hostWdata), .arbIdle(arbIdle),
    .swAck(swAck), .strobe(strobe), .st(st)
  );

  srb_datapath #(.NUM_EVT(NUM_EVT)) u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .st(st), .hostAddr(hostAddr),
    .hostWdata(hostWdata), .initDone(initDone), .evtPulse(evtPulse),
    .swRdata(swRdata), .hostRdata(hostRdata), .swWdata(swWdata), .irqOut(irqOut)
  );

  assign swReq   = st.busy;
  assign swWrite = st.isWrite;
  assign swPage  = st.page;
  assign swReg   = st.regOfs;

  a_r4_req_fields_hold: assert property (@(posedge clk) disable iff (!rstN)
    (swReq && !swAck) |=> (swReq && $stable({swPage, swReg, swWrite})));
endmodule

// File: tb/sw_reg_bridge_tb.sv
module sw_reg_bridge_tb;
  logic        clk = 1'b0;
  logic        rstN;
  logic        hostSel, hostWe;
  logic [7:0]  hostAddr;
  logic [31:0] hostWdata, hostRdata;
  logic        swReq, swWrite, swAck, arbIdle, initDone, irqOut;
  logic [7:0]  swPage, swReg;
  logic [63:0] swWdata, swRdata;
  logic [12:0] evtPulse;

  int nVec = 0;
  int nFail = 0;
  bit finished = 1'b0;

  always #4 clk = ~clk;

  sw_reg_bridge u_dut (
    .clk(clk), .rstN(rstN), .hostSel(hostSel), .hostWe(hostWe),
    .hostAddr(hostAddr), .hostWdata(hostWdata), .hostRdata(hostRdata),
    .swReq(swReq), .swWrite(swWrite), .swPage(swPage), .swReg(swReg),
    .swWdata(swWdata), .swAck(swAck), .swRdata(swRdata), .arbIdle(arbIdle),
    .initDone(initDone), .evtPulse(evtPulse), .irqOut(irqOut)
  );

  function automatic logic [63:0] switchModel(logic [7:0] p, logic [7:0] r);
    return {p, r, ~p, 8'h5A, r ^ p, 8'hC3, p + r, 8'h17};
  endfunction

  function automatic logic [31:0] cmdExp(logic [7:0] p, logic [7:0] r, logic wr, logic go);
    return {p, r, 14'b0, wr, go};
  endfunction

  task automatic chk(string tag, logic [63:0] act, logic [63:0] exp);
    nVec++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic hostWrite(logic [7:0] a, logic [31:0] d);
    @(negedge clk);
    hostSel = 1'b1; hostWe = 1'b1; hostAddr = a; hostWdata = d;
    @(negedge clk);
    hostSel = 1'b0; hostWe = 1'b0;
  endtask

  task automatic hostRead(logic [7:0] a, output logic [31:0] d);
    hostAddr = a;
    #1;
    d = hostRdata;
  endtask

  task automatic finish();
    finished = 1'b1;
    $display("  == %0d vectors applied, %0d miscompares ==", nVec, nFail);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      nFail++;
      $display("FAIL watchdog: run did not complete");
      finish();
    end
  end

  initial begin
    logic [31:0] rd;
    logic [12:0] pend;
    logic [63:0] lastRd;
    logic [31:0] ctlBase;
    void'($urandom(32'd20240611));
    rstN = 1'b0; hostSel = 1'b0; hostWe = 1'b0; hostAddr = '0; hostWdata = '0;
    swAck = 1'b0; swRdata = '0; arbIdle = 1'b1; initDone = 1'b0; evtPulse = '0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    // R1 reset state
    hostRead(8'h2C, rd); chk("R1 cmd", rd, 0);
    hostRead(8'h40, rd); chk("R1 ctl", rd, 0);
    hostRead(8'h44, rd); chk("R1 evt", rd, 0);
    hostRead(8'h38, rd); chk("R1 rdHi", rd, 0);
    hostRead(8'h3C, rd); chk("R1 rdLo", rd, 0);
    chk("R1 swReq", swReq, 0);
    chk("R1 irqOut", irqOut, 0);

    // R12 init flag
    initDone = 1'b1;
    hostRead(8'h40, rd); chk("R12 init bit", rd, 32'h40);
    ctlBase = 32'h40;

    // R5 command without request
    hostWrite(8'h2C, cmdExp(8'h12, 8'h34, 1'b0, 1'b1));
    hostRead(8'h2C, rd); chk("R5 no req", rd, 0);
    chk("R5 swReq", swReq, 0);

    // R2 grant withheld while arbiter busy
    arbIdle = 1'b0;
    hostWrite(8'h40, 32'h8);
    hostRead(8'h40, rd); chk("R2 req only", rd, ctlBase | 32'h8);
    repeat (3) @(negedge clk);
    hostRead(8'h40, rd); chk("R2 held", rd, ctlBase | 32'h8);
    hostWrite(8'h2C, cmdExp(8'h12, 8'h34, 1'b0, 1'b1));
    hostRead(8'h2C, rd); chk("R5 no grant", rd, 0);
    arbIdle = 1'b1;
    @(negedge clk);
    hostRead(8'h40, rd); chk("R2 grant", rd, ctlBase | 32'h18);

    // random transfers: R4 R6 R7 R8
    lastRd = '0;
    for (int t = 0; t < 40; t++) begin
      logic [7:0]  p, r;
      logic        wr;
      logic [31:0] hi, lo;
      int          dly;
      p = 8'($urandom); r = 8'($urandom); wr = 1'($urandom);
      hi = $urandom; lo = $urandom; dly = $urandom_range(0, 4);
      if (t == 0) begin p = 8'hFF; r = 8'h00; wr = 1'b0; end
      if (t == 1) begin p = 8'h00; r = 8'hFF; wr = 1'b1; hi = 32'h0000_BEEF; end
      if (wr) begin
        hostWrite(8'h30, hi);
        hostWrite(8'h34, lo);
        hostRead(8'h30, rd); chk("R8 word hi", rd, hi);
        hostRead(8'h34, rd); chk("R8 word lo", rd, lo);
      end
      hostWrite(8'h2C, cmdExp(p, r, wr, 1'b1));
      hostRead(8'h2C, rd); chk("R4 cmd readback", rd, cmdExp(p, r, wr, 1'b1));
      chk("R4 swReq", swReq, 1);
      chk("R4 fields", {swPage, swReg, swWrite}, {p, r, wr});
      if (wr) chk("R8 swWdata", swWdata, {hi, lo});
      if (t < 6) begin
        hostWrite(8'h2C, cmdExp(~p, ~r, ~wr, 1'b1));
        hostRead(8'h2C, rd); chk("R6 busy drop", rd, cmdExp(p, r, wr, 1'b1));
        chk("R6 fields", {swPage, swReg, swWrite}, {p, r, wr});
      end
      for (int k = 0; k < dly; k++) begin
        swRdata = {$urandom, $urandom};
        @(negedge clk);
        hostRead(8'h2C, rd); chk("R7 still busy", rd[0], 1);
      end
      swAck = 1'b1;
      swRdata = wr ? {$urandom, $urandom} : switchModel(p, r);
      @(negedge clk);
      swAck = 1'b0;
      hostRead(8'h2C, rd); chk("R7 busy clear", rd, cmdExp(p, r, wr, 1'b0));
      chk("R7 swReq low", swReq, 0);
      if (!wr) lastRd = switchModel(p, r);
      hostRead(8'h38, rd); chk("R7 read hi", rd, lastRd[63:32]);
      hostRead(8'h3C, rd); chk("R7 read lo", rd, lastRd[31:0]);
    end

    // R7 stray acknowledge while idle
    swAck = 1'b1; swRdata = 64'hDEAD_0000_BEEF_1111;
    @(negedge clk);
    swAck = 1'b0;
    hostRead(8'h38, rd); chk("R7 idle ack hi", rd, lastRd[63:32]);
    hostRead(8'h3C, rd); chk("R7 idle ack lo", rd, lastRd[31:0]);
    hostRead(8'h2C, rd); chk("R7 idle busy", rd[0], 0);

    // R3 release
    hostWrite(8'h40, 32'h0);
    hostRead(8'h40, rd); chk("R3 grant lingers", rd, ctlBase | 32'h10);
    @(negedge clk);
    hostRead(8'h40, rd); chk("R3 grant dropped", rd, ctlBase);
    hostWrite(8'h2C, cmdExp(8'h01, 8'h02, 1'b0, 1'b1));
    hostRead(8'h2C, rd); chk("R5 after release", rd[0], 0);

    // R9 R10 R11 events
    hostWrite(8'h44, 32'hFFFF_FFFF);
    pend = '0;
    @(negedge clk);
    evtPulse = 13'h1A05;
    @(negedge clk);
    evtPulse = '0;
    pend = 13'h1A05;
    hostRead(8'h44, rd); chk("R9 latch", rd, 32'(pend));
    chk("R11 gated off", irqOut, 0);
    hostWrite(8'h40, 32'h2);
    chk("R11 enabled", irqOut, 1);
    // directed: pulse and clear of bit 5 together
    @(negedge clk);
    evtPulse = 13'h0020; hostSel = 1'b1; hostWe = 1'b1; hostAddr = 8'h44; hostWdata = 32'h20;
    @(negedge clk);
    evtPulse = '0; hostSel = 1'b0; hostWe = 1'b0;
    pend = pend | 13'h0020;
    hostRead(8'h44, rd); chk("R10 pulse beats clear", rd, 32'(pend));
    for (int t = 0; t < 30; t++) begin
      logic [12:0] e;
      logic [31:0] c;
      e = 13'($urandom) & 13'($urandom);
      c = $urandom;
      @(negedge clk);
      evtPulse = e; hostSel = 1'b1; hostWe = 1'b1; hostAddr = 8'h44; hostWdata = c;
      @(negedge clk);
      evtPulse = '0; hostSel = 1'b0; hostWe = 1'b0;
      pend = (pend & ~c[12:0]) | e;
      hostRead(8'h44, rd); chk("R9 R10 mix", rd, 32'(pend));
      chk("R11 irq", irqOut, |pend);
    end
    hostWrite(8'h44, 32'hFFFF_FFFF);
    hostRead(8'h44, rd); chk("R9 clear all", rd, 0);
    chk("R11 irq idle", irqOut, 0);

    finish();
  end
endmodule